// File: doc/BRIEF.md
# Vertical-Blank Interrupt Controller

This block drives one level-sensitive interrupt line. The line is active while any bit that is pending in a status word is also enabled in an enable word. One status bit is fed by an internal period timer that stands in for the vertical-blank event. Nominally the timer fires sixty times per second, counted in cycles of the block clock. Every other status bit is set by a spare input pin of the same index, so other interrupt sources can share the line.

Software uses a single-cycle register port with two registers: the enable word and the status word. Writing the enable word with the vertical-blank bit set does three things. It posts a vertical-blank event at once, restarts the timer, and then repeats the event once per period. Writing the enable word with that bit clear stops the timer. Pending bits are cleared by writing ones to the status word, but only bits inside a fixed clear mask can be cleared that way.

There is no handshake on either side. A write is taken on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The port has no valid/ready pair because it never exerts back-pressure.

Top module: `vbi_ctrl`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the status word and the enable word is non-zero; with the enable word zero it stays low whatever is pending.
- R2: Address 0 is the enable word. A write there stores all 32 data bits, and a read returns them unchanged.
- R3: A write to address 1, the status word, clears each status bit written as 1 that lies inside the clear mask 0x000F040F. Bits outside the mask, such as bit 4, are left as they were.
- R4: While the timer runs, status bit 0 (the vertical-blank bit) is set once every `VBL_PERIOD` cycles.
- R5: A write to the enable word with bit 0 set sets status bit 0 on that same clock edge and restarts the timer. The next event then comes `VBL_PERIOD` cycles after that write, whatever the old schedule was.
- R6: A write to the enable word with bit 0 clear stops the timer, and no further vertical-blank events occur.
- R7: If a status bit is set and cleared on the same edge, the set wins and the bit stays pending.
- R8: A high level on `spare_set[i]` sets status bit i on the next edge, and the bit stays set after the input drops.
- R9: After reset the enable word and the status word are zero, the timer is stopped and `irq` is low.
- R10: Addresses 2 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Register select: 0 enable, 1 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| spare_set | input | DATA_W | Per-bit set requests from other interrupt sources |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that `bus_we`, `bus_addr`, `bus_wdata` and `spare_set` are synchronous to `clk` and stable around the rising edge. They also assume `VBL_PERIOD` is at least 2, so the counter has a terminal value distinct from its restart value. The bench changes every input only on the falling edge and holds each write for exactly one cycle. It runs the timer with a short period, so that periodic events, restarts and stops can be timed cycle by cycle. It drives a set and a clear onto the same bit in one cycle on purpose, to exercise the priority rule.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  // Register indices on the bus_addr field
  localparam int unsigned REG_ENABLE = 0;
  localparam int unsigned REG_STATUS = 1;
endpackage

// File: rtl/vbi_period_timer.sv
module vbi_period_timer #(
  parameter int unsigned PERIOD = 3_333_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic tick
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = run_q && (cnt_q == LAST);
  // start posts an event in the write cycle itself
  assign tick = start | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= LAST));
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == '0));
  a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !run_q);
  a_r6_idle_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !wrap);
endmodule

// File: rtl/vbi_status_reg.sv
module vbi_status_reg #(
  parameter int unsigned        DATA_W   = 32,
  parameter logic [DATA_W-1:0]  CLR_MASK = 32'h000F_040F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] status_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_clearable
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= set_bits[i] | (status_q[i] & ~(clr_we & clr_bits[i]));
      end
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= set_bits[i] | status_q[i];
      end
    end
  end

  assign status = status_q;

  a_r3_outside_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~CLR_MASK & $past(status_q & ~CLR_MASK))
              == $past(status_q & ~CLR_MASK)));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_bits)) == $past(set_bits)));
  a_r3_no_clear_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/vbi_ctrl.sv
module vbi_ctrl #(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       ADDR_W     = 2,
  parameter int unsigned       VBL_PERIOD = 3_333_333,
  parameter int unsigned       VBL_BIT    = 0,
  parameter logic [DATA_W-1:0] CLR_MASK   = 32'h000F_040F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] spare_set,
  output logic              irq
);
  import vbi_pkg::*;

  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STATUS);

  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] set_bits;
  logic              ena_wr, sts_wr, vbl_start, vbl_stop, vbl_tick;

  assign ena_wr    = bus_we && (bus_addr == A_ENA);
  assign sts_wr    = bus_we && (bus_addr == A_STS);
  assign vbl_start = ena_wr &&  bus_wdata[VBL_BIT];
  assign vbl_stop  = ena_wr && !bus_wdata[VBL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable_q <= '0;
    else if (ena_wr) enable_q <= bus_wdata;
  end

  vbi_period_timer #(.PERIOD(VBL_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (vbl_start),
    .stop  (vbl_stop),
    .tick  (vbl_tick)
  );

  always_comb begin
    set_bits = spare_set;
    set_bits[VBL_BIT] = spare_set[VBL_BIT] | vbl_tick;
  end

  vbi_status_reg #(.DATA_W(DATA_W), .CLR_MASK(CLR_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_we   (sts_wr),
    .clr_bits (bus_wdata),
    .status   (status)
  );

  always_comb begin
    unique case (bus_addr)
      A_ENA:   bus_rdata = enable_q;
      A_STS:   bus_rdata = status;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(status & enable_q);

  a_r1_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);
  a_r5_enable_posts: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_start |=> (status[VBL_BIT] && irq));
  a_r2_enable_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> (enable_q == $past(bus_wdata)));
  a_r10_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_wr |=> $stable(enable_q));
endmodule

// File: tb/tb_vbi_ctrl.sv
`timescale 1ns/100ps
module tb_vbi_ctrl;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] spare_set = '0;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int wr_cyc  = 0;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  event probe_ev;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vbi_ctrl #(.VBL_PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spare_set(spare_set), .irq(irq)
  );

  // Monitor: pops each expected item and compares it with the ports
  initial forever begin
    @(probe_ev);
    #1;
    begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (bus_rdata !== e.data || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, bus_rdata, irq, e.data, e.irq);
      end
    end
  end

  task automatic probe(input logic [1:0] a, input logic [31:0] d,
                       input logic i, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a;
    e.data = d; e.irq = i; e.tag = tag;
    exp_q.push_back(e);
    -> probe_ev;
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_vbl(output int at);
    bus_addr = 2'd1;
    forever begin
      @(negedge clk);
      #1;
      if (bus_rdata[0]) break;
    end
    at = cyc;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    probe(2'd0, 32'h0, 1'b0, "R9 enable after reset");
    probe(2'd1, 32'h0, 1'b0, "R9 status after reset");
    // R2 enable word holds a full value
    wr(2'd0, 32'hA5A5_0400);
    probe(2'd0, 32'hA5A5_0400, 1'b0, "R2 enable readback");
    wr(2'd0, 32'h0000_0400);
    // R8 spare pulse sets a sticky bit, R1 irq follows
    @(negedge clk); spare_set = 32'h0000_0400;
    @(negedge clk); spare_set = 32'h0;
    probe(2'd1, 32'h0000_0400, 1'b1, "R8 spare bit sticky / R1 irq high");
    // R3 clear inside mask; bit 4 outside mask survives
    @(negedge clk); spare_set = 32'h0000_0010;
    @(negedge clk); spare_set = 32'h0;
    wr(2'd1, 32'hFFFF_FFFF);
    probe(2'd1, 32'h0000_0010, 1'b0, "R3 masked clear, bit4 kept / R1 irq low");
    // R10 unmapped address
    wr(2'd2, 32'hFFFF_FFFF);
    probe(2'd2, 32'h0, 1'b0, "R10 unmapped reads zero");
    probe(2'd0, 32'h0000_0400, 1'b0, "R10 write ignored, enable kept");
    wr(2'd3, 32'h0000_0010);
    probe(2'd1, 32'h0000_0010, 1'b0, "R10 write ignored, status kept");
    // R5 enabling posts an event at once
    wr(2'd0, 32'h0000_0001);
    t0 = wr_cyc;
    probe(2'd1, 32'h0000_0011, 1'b1, "R5 immediate vblank event");
    wr(2'd1, 32'h0000_0001);
    probe(2'd1, 32'h0000_0010, 1'b0, "R3 vblank bit cleared");
    // R4 periodic events
    wait_vbl(t1);
    chk(t1 - t0, P, "R4 first period");
    wr(2'd1, 32'h0000_0001);
    wait_vbl(t2);
    chk(t2 - t1, P, "R4 second period");
    // R5 restart mid-period
    wr(2'd1, 32'h0000_0001);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h0000_0001);
    t0 = wr_cyc;
    wr(2'd1, 32'h0000_0001);
    wait_vbl(t1);
    chk(t1 - t0, P, "R5 restart realigns period");
    // R6 stop
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h0000_0001);
    repeat (3 * P) @(negedge clk);
    probe(2'd1, 32'h0000_0010, 1'b0, "R6 no event after stop");
    // R7 set beats clear on the same edge
    wr(2'd0, 32'h0000_0002);
    @(negedge clk);
    spare_set = 32'h0000_0002;
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    spare_set = 32'h0; bus_we = 1'b0;
    probe(2'd1, 32'h0000_0012, 1'b1, "R7 set wins over clear / R1");
    wr(2'd1, 32'h0000_0002);
    probe(2'd1, 32'h0000_0010, 1'b0, "R3 clear after set / R1 irq low");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule